// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a two-wire serial slave that lets a bus master read and write a 128-entry byte register file. It runs on a fast system clock and samples the clock and data lines through a synchronizer. It recognises START, repeated START and STOP. It answers one configured 7-bit address. After the address byte, a pointer byte selects the first register, and the top bit of that byte makes the pointer step after every byte. The block pulls the lines low only through output enables, so the two lines can be wired-AND on a shared bus.

A write is START, address with R/W=0, pointer byte, then any number of data bytes, then STOP. A read is the same two opening bytes, then a repeated START and the address with R/W=1. The slave then returns bytes until the master answers a byte with NACK, and a STOP follows. After every acknowledge slot the slave holds the clock low for a fixed number of system cycles. This models the time it needs to fetch or store a byte.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, neither line is pulled low (sdaOe=0, sclOe=0).
- R2: An address byte whose upper 7 bits equal SLAVE_ADDR is acknowledged by pulling SDA low in the ninth clock. Any other address leaves SDA released in that slot, and the slave ignores the rest of the transfer until the next START. Bit 0 of the address byte selects read (1) or write (0).
- R3: In the pointer byte, bit 7 set means auto-increment and bits 6..0 give the first register. With auto-increment, successive write bytes go to successive registers.
- R4: With bit 7 of the pointer byte clear, every data byte of a write or read targets the same register.
- R5: Read data leaves the slave most significant bit first. The slave changes its SDA drive only while SCL is low.
- R6: During a read, a master ACK (SDA low in the ninth clock) makes the slave send the next byte. After a master NACK the slave releases SDA and sends nothing more.
- R7: With auto-increment, the register pointer wraps from 127 to 0.
- R8: After every acknowledge slot in which the transfer continues, the slave holds SCL low for exactly STRETCH_CYCLES system cycles.
- R9: A START in the middle of a byte discards the partial byte and restarts address matching, and nothing is written.
- R10: After a STOP, both lines are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Level seen on the serial clock line |
| sdaIn | input | 1 | Level seen on the serial data line |
| sclOe | output | 1 | 1 pulls the clock line low (wait state) |
| sdaOe | output | 1 | 1 pulls the data line low |

## Verification
The bench builds the block with SLAVE_ADDR=7'h55, STRETCH_CYCLES=6 and the default two-stage synchronizer. The master in the bench runs ten system cycles per quarter bit, so each clock phase outlasts the synchronizer delay and the six-cycle wait state is long enough to count exactly. Because the register file is 128 entries deep, a three-byte burst that starts at register 126 reaches the wrap to 0.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 7;
  localparam int NUM_REGS = 1 << REG_AW;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_SUB, S_SUB_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RDATA_ACK
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic shiftOut;
    logic storeSub;
    logic writeReg;
    logic loadRead;
  } dp_ctl_t;

  // bus events and byte status from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaNow;
    logic byteFull;
    logic lastOut;
    logic addrHit;
    logic rwBit;
    logic txBit;
  } bus_ev_t;
endpackage

// File: rtl/i2c_rs_datapath.sv
module i2c_rs_datapath
  import i2c_regslave_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  dp_ctl_t ctl,
  output bus_ev_t ev
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [REG_AW-1:0] ptr;
  logic              autoInc;
  logic [BYTE_W-1:0] regFile [NUM_REGS];

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise   = sclNow & ~sclPrev;
    ev.sclFall   = ~sclNow & sclPrev;
    ev.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaNow    = sdaNow;
    ev.byteFull  = (bitCnt == CNT_W'(BYTE_W));
    ev.lastOut   = (bitCnt == CNT_W'(BYTE_W - 1));
    ev.addrHit   = (shiftReg[BYTE_W-1:1] == SLAVE_ADDR);
    ev.rwBit     = shiftReg[0];
    ev.txBit     = shiftReg[BYTE_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      ptr      <= '0;
      autoInc  <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (ctl.clrBits) bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftOut) bitCnt <= bitCnt + 1'b1;

      if (ctl.loadRead) shiftReg <= regFile[ptr];
      else if (ctl.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      else if (ctl.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};

      if (ctl.storeSub) begin
        ptr     <= shiftReg[REG_AW-1:0];
        autoInc <= shiftReg[BYTE_W-1];
      end else if (ctl.writeReg || ctl.loadRead) begin
        ptr <= ptr + REG_AW'(autoInc);
      end

      if (ctl.writeReg) regFile[ptr] <= shiftReg;
    end
  end
endmodule

// File: rtl/i2c_rs_control.sv
module i2c_rs_control
  import i2c_regslave_pkg::*;
#(
  parameter int STRETCH_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  bus_ev_t ev,
  output dp_ctl_t ctl,
  output logic    sdaOe,
  output logic    sclOe
);
  phase_t state, nxt;
  logic   masterAck;
  logic   armStretch;

  always_comb begin
    nxt        = state;
    ctl        = '0;
    armStretch = 1'b0;
    if (ev.startSeen) begin
      nxt         = S_ADDR;
      ctl.clrBits = 1'b1;
    end else if (ev.stopSeen) begin
      nxt = S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_SUB, S_WDATA: begin
          if (ev.sclRise && !ev.byteFull) ctl.shiftIn = 1'b1;
          else if (ev.sclFall && ev.byteFull) begin
            if (state == S_ADDR) nxt = ev.addrHit ? S_ADDR_ACK : S_IDLE;
            else if (state == S_SUB) begin
              ctl.storeSub = 1'b1;
              nxt          = S_SUB_ACK;
            end else begin
              ctl.writeReg = 1'b1;
              nxt          = S_WDATA_ACK;
            end
          end
        end
        S_ADDR_ACK: if (ev.sclFall) begin
          ctl.clrBits  = 1'b1;
          armStretch   = 1'b1;
          ctl.loadRead = ev.rwBit;
          nxt          = ev.rwBit ? S_RDATA : S_SUB;
        end
        S_SUB_ACK, S_WDATA_ACK: if (ev.sclFall) begin
          ctl.clrBits = 1'b1;
          armStretch  = 1'b1;
          nxt         = S_WDATA;
        end
        S_RDATA: if (ev.sclFall) begin
          if (ev.lastOut) nxt = S_RDATA_ACK;
          else ctl.shiftOut = 1'b1;
        end
        S_RDATA_ACK: if (ev.sclFall) begin
          if (masterAck) begin
            ctl.clrBits  = 1'b1;
            ctl.loadRead = 1'b1;
            armStretch   = 1'b1;
            nxt          = S_RDATA;
          end else nxt = S_IDLE;
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      masterAck <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_RDATA_ACK && ev.sclRise) masterAck <= ~ev.sdaNow;
    end
  end

  always_comb begin
    case (state)
      S_ADDR_ACK, S_SUB_ACK, S_WDATA_ACK: sdaOe = 1'b1;
      S_RDATA: sdaOe = ~ev.txBit;
      default: sdaOe = 1'b0;
    endcase
  end

  generate
    if (STRETCH_CYCLES > 0) begin : g_stretch
      localparam int SW = $clog2(STRETCH_CYCLES + 1) + 1;
      logic [SW-1:0] stretchCnt;
      always_ff @(posedge clk) begin
        if (!rstN) stretchCnt <= '0;
        else if (armStretch) stretchCnt <= SW'(STRETCH_CYCLES);
        else if (stretchCnt != '0) stretchCnt <= stretchCnt - 1'b1;
      end
      assign sclOe = (stretchCnt != '0);
    end else begin : g_nostretch
      logic unusedArm;
      assign unusedArm = armStretch;
      assign sclOe     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR     = 7'h2A,
  parameter int         STRETCH_CYCLES = 4,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclOe,
  output logic sdaOe
);
  dp_ctl_t ctl;
  bus_ev_t ev;

  i2c_rs_datapath #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl), .ev(ev)
  );

  i2c_rs_control #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .ctl(ctl), .sdaOe(sdaOe), .sclOe(sclOe)
  );
endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker #(
  parameter int STRETCH_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sclOe,
  input logic sdaOe
);
  int runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= 0;
    else runCnt <= sclOe ? runCnt + 1 : 0;
  end

  // R1: lines released when reset ends
  p_released_at_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sdaOe && !sclOe));

  // R5: SDA drive changes only while the clock line is low
  p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R8: every wait state lasts exactly STRETCH_CYCLES
  p_stretch_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOe) |-> (runCnt == STRETCH_CYCLES));

  // R8: a wait state never overruns its length
  p_stretch_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> (runCnt < STRETCH_CYCLES));
endmodule

bind i2c_regslave i2c_rs_checker #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sclOe(sclOe), .sdaOe(sdaOe)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam logic [6:0] SA = 7'h55;
  localparam int ST = 6;
  localparam int Q  = 10;

  // {wrSub, wrData[3], rdSub, expected[3]}
  localparam int NV = 5;
  localparam logic [63:0] VEC [NV] = '{
    64'h85_A1B2C3_85_A1B2C3,   // R3 R6 auto-increment write and read
    64'h10_112233_8F_003300,   // R4 fixed-register write
    64'hFE_5A6B7C_FE_5A6B7C,   // R7 wrap 127 -> 0
    64'h05_0FF03C_84_003CB2,   // R4 then R3 read across
    64'h86_010203_07_020202    // R4 fixed-register read
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe;
  wire  sclLine = mScl & ~sclOe;
  wire  sdaLine = mSda & ~sdaOe;
  int compared = 0, mismatched = 0, stretchSeen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_regslave #(.SLAVE_ADDR(SA), .STRETCH_CYCLES(ST)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  always @(negedge clk) if (sclOe === 1'b1) stretchSeen++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    do tick(1); while (sclLine !== 1'b1);
  endtask

  task automatic startCond();
    mSda = 1'b1; tick(Q); sclHigh(); tick(Q);
    mSda = 1'b0; tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; tick(Q); sclHigh(); tick(Q); mSda = 1'b1; tick(Q);
  endtask

  task automatic writeBit(input logic b);
    mSda = b; tick(Q); sclHigh(); tick(2 * Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; tick(Q); sclHigh(); tick(Q); b = sdaLine; tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output int ack);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(a);
    ack = (a == 1'b0) ? 1 : 0;
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) readBit(v[i]);
    writeBit(~mack);
  endtask

  task automatic writeTxn(input logic [7:0] sub, input logic [23:0] d, output int acks);
    int a;
    acks = 0;
    startCond();
    sendByte({SA, 1'b0}, a); acks += a;
    sendByte(sub, a); acks += a;
    for (int i = 2; i >= 0; i--) begin
      sendByte(d[i*8 +: 8], a); acks += a;
    end
    stopCond();
  endtask

  task automatic readTxn(input logic [7:0] sub, output logic [23:0] got, output int acks);
    int a;
    logic [7:0] v;
    acks = 0;
    startCond();
    sendByte({SA, 1'b0}, a); acks += a;
    sendByte(sub, a); acks += a;
    startCond();
    sendByte({SA, 1'b1}, a); acks += a;
    for (int i = 2; i >= 0; i--) begin
      recvByte(i != 0, v);
      got[i*8 +: 8] = v;
    end
    check("R6 SDA released after NACK", {31'd0, sdaOe}, 32'd0);
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    int acks, s0;
    logic [23:0] got;
    logic [7:0] v;
    logic b;
    tick(5);
    rstN = 1'b1;
    tick(3);
    check("R1 sdaOe after reset", {31'd0, sdaOe}, 32'd0);
    check("R1 sclOe after reset", {31'd0, sclOe}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      s0 = stretchSeen;
      writeTxn(VEC[k][63:56], VEC[k][55:32], acks);
      check($sformatf("R2 write acks vec %0d", k), acks, 5);
      check($sformatf("R8 write wait cycles vec %0d", k), stretchSeen - s0, 5 * ST);
      check("R10 lines idle after STOP", {30'd0, sclOe, sdaOe}, 32'd0);
      s0 = stretchSeen;
      readTxn(VEC[k][31:24], got, acks);
      check($sformatf("R2 read acks vec %0d", k), acks, 3);
      check($sformatf("R8 read wait cycles vec %0d", k), stretchSeen - s0, 5 * ST);
      check($sformatf("R5 read data vec %0d", k), {8'd0, got}, {8'd0, VEC[k][23:0]});
    end

    // R2: wrong address gets no ACK and the rest of the transfer is ignored
    startCond();
    sendByte({SA ^ 7'h01, 1'b0}, acks);
    check("R2 no ack on wrong address", acks, 0);
    sendByte(8'h83, acks);
    check("R2 pointer byte ignored", acks, 0);
    sendByte(8'hEE, acks);
    check("R2 data byte ignored", acks, 0);
    stopCond();
    readTxn(8'h83, got, acks);
    check("R2 register 3 unchanged", {8'd0, got}, 32'h0000003C);

    // R9: START inside a data byte restarts address matching, no write
    startCond();
    sendByte({SA, 1'b0}, acks);
    sendByte(8'h09, acks);
    for (int i = 0; i < 4; i++) writeBit(1'b1);
    startCond();
    sendByte({SA, 1'b1}, acks);
    check("R9 address ack after restart", acks, 1);
    recvByte(1'b0, v);
    check("R9 partial byte not written", {24'd0, v}, 32'h00);
    readBit(b);
    check("R6 nothing sent after NACK", {31'd0, b}, 32'd1);
    stopCond();
    check("R10 lines idle after final STOP", {30'd0, sclOe, sdaOe}, 32'd0);

    tick(20);
    finishRun();
  end
endmodule